// File: doc/BRIEF.md
# Round-Robin Crossing Event Distributor

The block takes one fixed-length frame of words in each crossing period and deals whole frames out to a ring of processing-node ports. Frames go to the nodes in turn. Each frame lands in a ping-pong buffer on its port and is then played out at one word every `NODES` clock cycles. A port therefore spends `NODES` crossing periods delivering one event, which is the time it has before its next event arrives. Every outgoing word carries a first-word flag, the crossing number taken with the frame's first input word, and a node tag.

A failure mask marks dead nodes. The lowest-numbered failed node loses its frames to a spare backup port, which tags each word with the node index it is standing in for. All other slots keep their normal rotation. If more than one node is marked failed, an error flag goes high. The slots of the extra failed nodes are then dropped. When no node has failed, the backup port stays idle.

An input frame is `FRAME_WORDS` words on consecutive cycles. `in_first` is high on word 0 and `in_valid` is high on every word. A crossing period is therefore `FRAME_WORDS` cycles long.

Top module: `tdm_event_distributor`

## Requirements
- R1: Frame k after reset, counting from 0, is written to node port k mod `NODES`. The rotation wraps from `NODES`-1 to 0 and advances once per `in_first`.
- R2: A port presents the words of a frame one cycle in every `NODES`. Word j appears `j*NODES` cycles after word 0. The first flag is high on word 0 only.
- R3: The first output word of a frame is presented `FRAME_WORDS`+1 cycles after the cycle in which its first input word was presented. This is one crossing period plus one register stage.
- R4: Every output word of a frame carries the 12-bit crossing number that was presented on `in_bx` with the frame's first input word.
- R5: All `FRAME_WORDS` words of a frame reach the output in input order with unchanged data, and no word is lost.
- R6: A slot whose node is failed, where that node is the lowest-numbered failed node, is delivered on the backup port instead. The backup port uses the same timing, and `bak_node` equals that node index. The failed node's own port presents nothing for that slot.
- R7: With no node failed, the backup port presents no valid word.
- R8: When two or more mask bits are set, `fail_err` is high. Slots of the failed nodes other than the lowest-numbered one appear on no port.
- R9: Reset clears all output valids and returns the rotation so that the next frame goes to node 0.
- R10: While a port's valid is low, its data and crossing-number outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_first | input | 1 | Word 0 of a crossing's frame |
| in_bx | input | 12 | Crossing number, taken on word 0 |
| in_data | input | 16 | Input data word |
| fail_mask | input | NODES | One bit per node; 1 marks the node failed |
| node_valid | output | NODES | Per-node output word present |
| node_first | output | NODES | Per-node first-word flag |
| node_bx | output | NODES*12 | Per-node crossing number, node k at bits [12k+11:12k] |
| node_data | output | NODES*16 | Per-node data, node k at bits [16k+15:16k] |
| bak_valid | output | 1 | Backup port word present |
| bak_first | output | 1 | Backup port first-word flag |
| bak_bx | output | 12 | Backup port crossing number |
| bak_data | output | 16 | Backup port data |
| bak_node | output | 4 | Node index the backup word stands in for |
| fail_err | output | 1 | More than one node marked failed |

## Verification
The block can hold the wrong internal state in several ways, and each one shows up at the ports. A rotation pointer that is off by one, or that wraps wrongly, puts a whole frame on the wrong port. The model sees this as a stray valid word `FRAME_WORDS`+1 cycles after that frame's first input word. A swapped ping-pong bank select or a bad divider count corrupts data or spacing on the very next output word, which comes `NODES` cycles later. A bad failover decode shows as words on a dead port or as a backup port that stays silent, in the first readout of the affected slot. Every port is compared against an independent model on every cycle, so each of these faults is caught within one frame's readout.

// File: rtl/tdm_dist_pkg.sv
package tdm_dist_pkg;

    localparam int DATA_W    = 16;
    localparam int BX_W      = 12;
    localparam int MAX_NODES = 16;
    localparam int NODE_W    = $clog2(MAX_NODES);

    typedef logic [DATA_W-1:0]    word_t;
    typedef logic [BX_W-1:0]      bx_t;
    typedef logic [NODE_W-1:0]    node_t;
    typedef logic [MAX_NODES-1:0] mask_t;

    // One output beat of a node port
    typedef struct packed {
        logic  vld;
        logic  first;
        node_t node;
        bx_t   bx;
        word_t data;
    } out_beat_t;

    // Lowest index with its bit set (0 when none set)
    function automatic node_t lowest_set(input mask_t m);
        node_t r;
        r = '0;
        for (int i = MAX_NODES - 1; i >= 0; i--) begin
            if (m[i]) r = node_t'(i);
        end
        return r;
    endfunction

    // Successor of a slot in a ring of n nodes
    function automatic node_t ring_next(input node_t s, input int n);
        return (int'(s) == n - 1) ? '0 : node_t'(s + 1'b1);
    endfunction

endpackage

// File: rtl/tdm_rotator.sv
module tdm_rotator
    import tdm_dist_pkg::*;
#(
    parameter int NODES       = 10,
    parameter int FRAME_WORDS = 8,
    localparam int IDX_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_first,
    output logic             wr_go,
    output node_t            wr_slot,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_last
);

    node_t            ptr;
    node_t            cur_slot;
    logic [IDX_W-1:0] widx;
    logic             in_frame;

    always_comb begin
        wr_go   = in_valid && (in_first || in_frame);
        wr_slot = in_first ? ptr : cur_slot;
        wr_idx  = in_first ? '0 : widx;
        wr_last = wr_go && (wr_idx == IDX_W'(FRAME_WORDS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            cur_slot <= '0;
            widx     <= '0;
            in_frame <= 1'b0;
        end else if (in_valid && in_first) begin
            cur_slot <= ptr;
            ptr      <= ring_next(ptr, NODES);
            widx     <= IDX_W'(1);
            in_frame <= (FRAME_WORDS > 1);
        end else if (wr_go) begin
            if (wr_last) in_frame <= 1'b0;
            else         widx     <= widx + 1'b1;
        end
    end

    // The rotation pointer never leaves the ring
    assert_ptr_in_ring_R1: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < NODES);

    // A crossing strobe always steps the pointer to another node
    assert_ptr_steps_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_first) |=> (ptr != $past(ptr)));

endmodule

// File: rtl/tdm_failover.sv
module tdm_failover
    import tdm_dist_pkg::*;
#(
    parameter int NODES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  node_t            wr_slot,
    input  logic [NODES-1:0] fail_mask,
    output logic [NODES-1:0] node_we,
    output logic             bak_we,
    output node_t            bak_tag,
    output logic             dual_fail
);

    mask_t padded;
    logic  any_fail;

    always_comb begin
        padded    = mask_t'(fail_mask);
        any_fail  = |fail_mask;
        bak_tag   = lowest_set(padded);
        dual_fail = ($countones(fail_mask) > 1);
        bak_we    = wr_go && any_fail && (wr_slot == bak_tag);
    end

    for (genvar k = 0; k < NODES; k++) begin : g_we
        assign node_we[k] = wr_go && (wr_slot == node_t'(k)) && !fail_mask[k];
    end

    // A frame word is written to at most one port
    assert_single_dest_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({node_we, bak_we}));

    // A failed node never takes a write
    assert_failed_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (node_we & fail_mask) == '0);

    // With two failures, a write to the backup serves only the lowest index
    assert_drop_second_R8: assert property (@(posedge clk) disable iff (rst)
        (dual_fail && bak_we) |-> fail_mask[wr_slot]);

endmodule

// File: rtl/tdm_port.sv
module tdm_port
    import tdm_dist_pkg::*;
#(
    parameter int NODES       = 10,
    parameter int FRAME_WORDS = 8,
    localparam int IDX_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
    localparam int DIV_W      = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wlast,
    input  word_t            wdata,
    input  bx_t              wbx,
    input  node_t            tag,
    output out_beat_t        beat
);

    word_t            mem [2][FRAME_WORDS];
    bx_t              bank_bx  [2];
    node_t            bank_tag [2];
    logic             wbank;
    logic             rbank;
    logic             rd_on;
    logic [DIV_W-1:0] div;
    logic [IDX_W-1:0] ridx;

    // Frame storage: writes land in the bank not being read
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wbank][widx] <= wdata;
            if (widx == '0) begin
                bank_bx[wbank]  <= wbx;
                bank_tag[wbank] <= tag;
            end
        end
    end

    // Bank swap and slowed readout: one word every NODES cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            wbank <= 1'b0;
            rbank <= 1'b0;
            rd_on <= 1'b0;
            div   <= '0;
            ridx  <= '0;
            beat  <= '0;
        end else begin
            beat <= '0;
            if (rd_on) begin
                if (div == '0) begin
                    beat.vld   <= 1'b1;
                    beat.first <= (ridx == '0);
                    beat.node  <= bank_tag[rbank];
                    beat.bx    <= bank_bx[rbank];
                    beat.data  <= mem[rbank][ridx];
                end
                if (div == DIV_W'(NODES - 1)) begin
                    div <= '0;
                    if (ridx == IDX_W'(FRAME_WORDS - 1)) rd_on <= 1'b0;
                    else                                 ridx  <= ridx + 1'b1;
                end else begin
                    div <= div + 1'b1;
                end
            end
            if (we && wlast) begin
                wbank <= ~wbank;
                rbank <= wbank;
                rd_on <= 1'b1;
                div   <= '0;
                ridx  <= '0;
            end
        end
    end

    // Output words are never adjacent
    assert_word_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        beat.vld |=> !beat.vld);

    // The first flag only rides on a valid word
    assert_first_valid_R2: assert property (@(posedge clk) disable iff (rst)
        beat.first |-> beat.vld);

    // Idle beats carry no data or crossing number
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !beat.vld |-> (beat.data == '0 && beat.bx == '0));

    // A new frame never completes while the previous one is still mid-readout
    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        (we && wlast) |-> (!rd_on || (ridx == IDX_W'(FRAME_WORDS - 1))));

endmodule

// File: rtl/tdm_event_distributor.sv
module tdm_event_distributor
    import tdm_dist_pkg::*;
#(
    parameter int NODES       = 10,
    parameter int FRAME_WORDS = 8,
    localparam int IDX_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic [BX_W-1:0]          in_bx,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [NODES-1:0]         fail_mask,
    output logic [NODES-1:0]         node_valid,
    output logic [NODES-1:0]         node_first,
    output logic [NODES*BX_W-1:0]    node_bx,
    output logic [NODES*DATA_W-1:0]  node_data,
    output logic                     bak_valid,
    output logic                     bak_first,
    output logic [BX_W-1:0]          bak_bx,
    output logic [DATA_W-1:0]        bak_data,
    output logic [NODE_W-1:0]        bak_node,
    output logic                     fail_err
);

    logic             wr_go;
    node_t            wr_slot;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_last;
    logic [NODES-1:0] node_we;
    logic             bak_we;
    node_t            bak_tag;
    out_beat_t        beat [NODES];
    out_beat_t        bak_beat;

    tdm_rotator #(.NODES(NODES), .FRAME_WORDS(FRAME_WORDS)) u_rot (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_first (in_first),
        .wr_go    (wr_go),
        .wr_slot  (wr_slot),
        .wr_idx   (wr_idx),
        .wr_last  (wr_last)
    );

    tdm_failover #(.NODES(NODES)) u_fo (
        .clk       (clk),
        .rst       (rst),
        .wr_go     (wr_go),
        .wr_slot   (wr_slot),
        .fail_mask (fail_mask),
        .node_we   (node_we),
        .bak_we    (bak_we),
        .bak_tag   (bak_tag),
        .dual_fail (fail_err)
    );

    for (genvar k = 0; k < NODES; k++) begin : g_node
        tdm_port #(.NODES(NODES), .FRAME_WORDS(FRAME_WORDS)) u_port (
            .clk   (clk),
            .rst   (rst),
            .we    (node_we[k]),
            .widx  (wr_idx),
            .wlast (wr_last),
            .wdata (in_data),
            .wbx   (in_bx),
            .tag   (node_t'(k)),
            .beat  (beat[k])
        );
        assign node_valid[k]                   = beat[k].vld;
        assign node_first[k]                   = beat[k].first;
        assign node_bx[k*BX_W +: BX_W]         = beat[k].bx;
        assign node_data[k*DATA_W +: DATA_W]   = beat[k].data;
    end

    tdm_port #(.NODES(NODES), .FRAME_WORDS(FRAME_WORDS)) u_bak (
        .clk   (clk),
        .rst   (rst),
        .we    (bak_we),
        .widx  (wr_idx),
        .wlast (wr_last),
        .wdata (in_data),
        .wbx   (in_bx),
        .tag   (bak_tag),
        .beat  (bak_beat)
    );

    assign bak_valid = bak_beat.vld;
    assign bak_first = bak_beat.first;
    assign bak_bx    = bak_beat.bx;
    assign bak_data  = bak_beat.data;
    assign bak_node  = bak_beat.node;

    // Reset leaves every port silent on the next cycle
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (node_valid == '0 && !bak_valid));

endmodule

// File: tb/tdm_event_distributor_test.sv
module tdm_event_distributor_test;
    localparam int N  = 10;
    localparam int F  = 8;
    localparam int NF = 2 * N + 3;    // frames per run

    // Run table: {expected fail_err, fail_mask}
    localparam logic [N:0] RUNS [4] = '{
        {1'b0, 10'h000},              // R7: no failure, backup idle
        {1'b0, 10'h008},              // R6: node 3 failed
        {1'b0, 10'h200},              // R6: node 9 failed (ring wrap)
        {1'b1, 10'h044}               // R8: nodes 2 and 6 failed
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid, in_first;
    logic [11:0]     in_bx;
    logic [15:0]     in_data;
    logic [N-1:0]    fail_mask;
    logic [N-1:0]    node_valid, node_first;
    logic [N*12-1:0] node_bx;
    logic [N*16-1:0] node_data;
    logic            bak_valid, bak_first;
    logic [11:0]     bak_bx;
    logic [15:0]     bak_data;
    logic [3:0]      bak_node;
    logic            fail_err;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit chk_en  = 0;
    bit done    = 0;
    int nfr     = 0;
    int start_c [NF];

    tdm_event_distributor #(.NODES(N), .FRAME_WORDS(F)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_bx(in_bx), .in_data(in_data), .fail_mask(fail_mask),
        .node_valid(node_valid), .node_first(node_first),
        .node_bx(node_bx), .node_data(node_data),
        .bak_valid(bak_valid), .bak_first(bak_first), .bak_bx(bak_bx),
        .bak_data(bak_data), .bak_node(bak_node), .fail_err(fail_err)
    );

    always #2.5 clk = ~clk;           // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int first_fail(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    // Model: every port, every cycle, against frames driven this run
    always @(negedge clk) begin
        if (chk_en) begin
            for (int p = 0; p <= N; p++) begin
                logic        ev, ef, av, af;
                logic [15:0] ed, ad;
                logic [11:0] eb, ab;
                ev = 0; ef = 0; ed = '0; eb = '0;
                for (int f = 0; f < nfr; f++) begin
                    int n, dst, d;
                    n   = f % N;                                  // R1
                    dst = !fail_mask[n] ? n :
                          (n == first_fail(fail_mask) ? N : -1);  // R6 R8
                    d   = cyc - (start_c[f] + F + 1);             // R3
                    if (dst == p && d >= 0 && d % N == 0 && d / N < F) begin
                        ev = 1; ef = (d == 0);
                        ed = {f[7:0], 8'(d / N)};                 // R5
                        eb = 12'(f * 7 + 100);                    // R4
                    end
                end
                if (p < N) begin
                    av = node_valid[p]; af = node_first[p];
                    ad = node_data[p*16 +: 16]; ab = node_bx[p*12 +: 12];
                end else begin
                    av = bak_valid; af = bak_first; ad = bak_data; ab = bak_bx;
                end
                vectors++;
                if (av !== ev) begin
                    errors++;
                    $display("FAIL R3 R1 port %0d cyc %0d valid act %0b exp %0b", p, cyc, av, ev);
                end else if (ev) begin
                    if (af !== ef) begin
                        errors++;
                        $display("FAIL R2 port %0d first act %0b exp %0b", p, af, ef);
                    end
                    if (ad !== ed) begin
                        errors++;
                        $display("FAIL R5 port %0d data act %h exp %h", p, ad, ed);
                    end
                    if (ab !== eb) begin
                        errors++;
                        $display("FAIL R4 port %0d bx act %h exp %h", p, ab, eb);
                    end
                    if (p == N && int'(bak_node) != first_fail(fail_mask)) begin
                        errors++;
                        $display("FAIL R6 bak_node act %0d exp %0d", bak_node, first_fail(fail_mask));
                    end
                end else if (ad !== '0 || ab !== '0) begin
                    errors++;
                    $display("FAIL R10 port %0d idle data %h bx %h exp 0", p, ad, ab);
                end
            end
        end
    end

    task automatic do_reset();
        chk_en = 0;
        @(posedge clk); #1;
        rst = 1; in_valid = 0; in_first = 0; in_bx = '0; in_data = '0;
        nfr = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        vectors++;                    // R9: everything quiet after reset
        if (node_valid !== '0 || bak_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 valids act %b/%b exp 0/0", node_valid, bak_valid);
        end
        chk_en = 1;
    endtask

    task automatic drive_frames(input int count);
        for (int f = 0; f < count; f++) begin
            for (int j = 0; j < F; j++) begin
                @(posedge clk); #1;
                if (j == 0) begin
                    start_c[f] = cyc;
                    nfr = f + 1;
                end
                in_valid = 1;
                in_first = (j == 0);
                in_bx    = (j == 0) ? 12'(f * 7 + 100) : 12'hABC;
                in_data  = {f[7:0], 8'(j)};
            end
        end
        @(posedge clk); #1;
        in_valid = 0; in_first = 0; in_data = '0; in_bx = '0;
    endtask

    initial begin
        rst = 1; fail_mask = '0;
        in_valid = 0; in_first = 0; in_bx = '0; in_data = '0;
        for (int r = 0; r < 4; r++) begin
            fail_mask = RUNS[r][N-1:0];
            do_reset();               // R9: each run must start at node 0
            vectors++;                // R8 error flag
            if (fail_err !== RUNS[r][N]) begin
                errors++;
                $display("FAIL R8 fail_err act %0b exp %0b", fail_err, RUNS[r][N]);
            end
            drive_frames(NF);
            repeat (N * F + F + 10) @(posedge clk);
        end
        // Directed: reset in the middle of a readout, then a fresh frame to node 0
        fail_mask = '0;
        do_reset();
        drive_frames(3);
        repeat (F + 2 * N) @(posedge clk);
        do_reset();                   // R9 mid-run reset
        drive_frames(2);
        repeat (N * F + F + 10) @(posedge clk);
        chk_en = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule